// File: doc/BRIEF.md
# Static-Predicting Branch Resolution Unit

This block decides the direction of each branch that arrives from dispatch and names the next fetch address in the same cycle. It checks the branch against an eight-field condition register, in which every field has a busy flag raised by pending writers, and against a loop counter that it owns. Unconditional branches, counter-only branches and branches whose condition field is idle are resolved at once. A branch on a busy field is instead given a static guess. Backward displacements are guessed taken and forward ones not taken, and an encoding hint bit inverts the guess. The branch is then marked speculative, and the address of the path not chosen is kept.

Only one guessed branch may be in flight. On every cycle it is outstanding, the unit watches for the field's busy flag to drop, or for a compare result forwarded from the integer pipeline for that field. When either appears, the unit either confirms the guess or raises a redirect that carries the saved address, which tells fetch to throw away the speculative work. Branch-and-link forms store the sequential return address in a link register.

Top module: `branch_resolver`

## Requirements
- R1: After reset, `pend`, `confirm` and `redirect` are 0, and `lr` and `ctr` are 0.
- R2: A valid branch with neither `br_use_cr` nor `br_use_ctr` is accepted in its arrival cycle, is taken, is not speculative, and `fetch_addr` = `br_pc + br_disp`.
- R3: An accepted branch with `br_use_ctr` decrements `ctr` by one at the next edge. Its counter test passes when `br_ctr_zero`=1 and the decremented value is zero, or when `br_ctr_zero`=0 and that value is nonzero. A counter-only branch is taken exactly when the test passes. A not-taken branch fetches `br_pc + 4`.
- R4: A branch with `br_use_cr` whose field is not busy is resolved in its arrival cycle and is taken when `cr_value[br_cr_idx]` equals `br_sense`. Here `br_cr_idx[4:2]` selects the field, `br_cr_idx[1:0]` selects the bit within the field, and field f occupies `cr_value[4f+3:4f]`.
- R5: A branch on a busy field is accepted as speculative (`br_spec`=1) and guessed taken when `br_disp[31]` XOR `br_hint` is 1. `pend` is 1 from the next cycle.
- R6: While `pend`=1, a release of the field (busy bit 0) whose bit disagrees with the guess asserts `redirect` in that cycle. `redirect_addr` is then the non-guessed address: `br_pc + 4` if the guess was taken, and `br_pc + br_disp` otherwise. `pend` is 0 from the next cycle.
- R7: A resolution that agrees with the guess asserts `confirm` and not `redirect`, and clears `pend`.
- R8: A forwarded result (`fwd_valid`, `fwd_field` equal to the pending field, `fwd_bits` being that field's four bits) resolves the pending branch even while the field is still busy.
- R9: An accepted branch with `br_link`=1 writes `br_pc + 4` into `lr` at the next edge.
- R10: While `pend`=1, a new branch that needs a guess is stalled (`br_stall`=1, `br_accept`=0). A branch that needs no guess is still accepted.
- R11: A branch that uses both the counter and a busy field is resolved not taken at once, and not speculatively, when its counter test fails.
- R12: A branch that arrives in a `redirect` cycle is not accepted and changes neither `lr` nor `ctr`.
- R13: `ctr_wr` loads `ctr_wdata` into `ctr` at the next edge when no accepted branch decrements the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch is presented |
| br_pc | input | 32 | Address of the branch |
| br_disp | input | 32 | Signed displacement |
| br_use_cr | input | 1 | Branch tests a condition bit |
| br_use_ctr | input | 1 | Branch decrements and tests the counter |
| br_ctr_zero | input | 1 | Counter test: 1 = zero, 0 = nonzero |
| br_cr_idx | input | 5 | Condition bit index (field, bit) |
| br_sense | input | 1 | Bit value that makes the branch taken |
| br_hint | input | 1 | Inverts the static guess |
| br_link | input | 1 | Store the return address in the link register |
| cr_value | input | 32 | Condition register contents |
| cr_busy | input | 8 | Per-field busy flags |
| fwd_valid | input | 1 | Forwarded compare result valid |
| fwd_field | input | 3 | Field the forwarded result targets |
| fwd_bits | input | 4 | Forwarded field value |
| ctr_wr | input | 1 | Load the counter |
| ctr_wdata | input | 32 | Counter load value |
| br_accept | output | 1 | Branch consumed this cycle |
| br_stall | output | 1 | Branch held for an outstanding guess |
| br_taken | output | 1 | Resolved or guessed direction |
| br_spec | output | 1 | Accepted branch was guessed |
| fetch_addr | output | 32 | Next fetch address for the branch |
| pend | output | 1 | A guessed branch is outstanding |
| confirm | output | 1 | Outstanding guess proved correct |
| redirect | output | 1 | Outstanding guess was wrong; discard and refetch |
| redirect_addr | output | 32 | Saved alternate path address |
| lr | output | 32 | Link register |
| ctr | output | 32 | Loop counter |

## Verification
If the saved guess or the saved alternate address is corrupted, it shows at the resolution cycle. The wrong one of `confirm` and `redirect` fires, or `redirect_addr` points at the guessed path instead of the other one. A stuck `pend` shows within one cycle as a stalled branch that should have been accepted, or as no resolution pulse. Counter or link corruption is visible on `ctr` and `lr` one edge after the accepting cycle, and a wrong counter also flips the direction of the next counter branch.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int NF   = 8,
  parameter int ILEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       br_valid,
  input  logic [AW-1:0]              br_pc,
  input  logic [AW-1:0]              br_disp,
  input  logic                       br_use_cr,
  input  logic                       br_use_ctr,
  input  logic                       br_ctr_zero,
  input  logic [$clog2(NF*4)-1:0]    br_cr_idx,
  input  logic                       br_sense,
  input  logic                       br_hint,
  input  logic                       br_link,
  input  logic [NF*4-1:0]            cr_value,
  input  logic [NF-1:0]              cr_busy,
  input  logic                       fwd_valid,
  input  logic [$clog2(NF)-1:0]      fwd_field,
  input  logic [3:0]                 fwd_bits,
  input  logic                       ctr_wr,
  input  logic [CW-1:0]              ctr_wdata,
  output logic                       br_accept,
  output logic                       br_stall,
  output logic                       br_taken,
  output logic                       br_spec,
  output logic [AW-1:0]              fetch_addr,
  output logic                       pend,
  output logic                       confirm,
  output logic                       redirect,
  output logic [AW-1:0]              redirect_addr,
  output logic [AW-1:0]              lr,
  output logic [CW-1:0]              ctr
);
  localparam int FW  = 4;
  localparam int BW  = $clog2(FW);
  localparam int IW  = $clog2(NF*FW);
  localparam int FIW = $clog2(NF);

  logic [FIW-1:0] p_field;
  logic [BW-1:0]  p_bit;
  logic           p_sense, p_guess;
  logic [AW-1:0]  p_alt;

  wire [FIW-1:0] fld      = br_cr_idx[IW-1:BW];
  wire [CW-1:0]  ctr_dec  = ctr - CW'(1);
  wire           ctr_ok   = br_ctr_zero ? (ctr_dec == '0) : (ctr_dec != '0);
  wire           ctr_fail = br_use_ctr && !ctr_ok;
  wire           cr_ok    = cr_value[br_cr_idx] == br_sense;
  wire           need_g   = br_use_cr && cr_busy[fld] && !ctr_fail;
  wire           guess    = br_disp[AW-1] ^ br_hint;
  wire [AW-1:0]  seq_a    = br_pc + AW'(ILEN);
  wire [AW-1:0]  tgt_a    = br_pc + br_disp;

  wire           fwd_hit  = fwd_valid && (fwd_field == p_field);
  wire [FW-1:0]  res_bits = fwd_hit ? fwd_bits : cr_value[p_field*FW +: FW];
  wire           res_rdy  = pend && (fwd_hit || !cr_busy[p_field]);
  wire           outcome  = res_bits[p_bit] == p_sense;

  assign confirm       = res_rdy && (outcome == p_guess);
  assign redirect      = res_rdy && (outcome != p_guess);
  assign redirect_addr = p_alt;

  assign br_stall   = br_valid && need_g && pend;
  assign br_accept  = br_valid && !br_stall && !redirect;
  assign br_taken   = need_g ? guess : (!ctr_fail && (!br_use_cr || cr_ok));
  assign br_spec    = br_accept && need_g;
  assign fetch_addr = br_taken ? tgt_a : seq_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      p_field <= '0;
      p_bit   <= '0;
      p_sense <= 1'b0;
      p_guess <= 1'b0;
      p_alt   <= '0;
      lr      <= '0;
      ctr     <= '0;
    end else begin
      if (br_spec) begin
        pend    <= 1'b1;
        p_field <= fld;
        p_bit   <= br_cr_idx[BW-1:0];
        p_sense <= br_sense;
        p_guess <= guess;
        p_alt   <= guess ? seq_a : tgt_a;
      end else if (res_rdy) begin
        pend <= 1'b0;
      end
      if (br_accept && br_link) lr <= seq_a;
      if (br_accept && br_use_ctr) ctr <= ctr_dec;
      else if (ctr_wr)             ctr <= ctr_wdata;
    end
  end
endmodule

module branch_resolver_chk #(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int ILEN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_valid,
  input logic [AW-1:0] br_pc,
  input logic          br_use_cr,
  input logic          br_use_ctr,
  input logic          br_link,
  input logic          br_accept,
  input logic          br_stall,
  input logic          br_taken,
  input logic          br_spec,
  input logic          pend,
  input logic          confirm,
  input logic          redirect,
  input logic [AW-1:0] lr,
  input logic [CW-1:0] ctr
);
  a_r2_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !br_use_cr && !br_use_ctr |-> br_taken && !br_spec);
  a_r3_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    br_accept && br_use_ctr |=> ctr == CW'($past(ctr) - CW'(1)));
  a_r5_spec_arms: assert property (@(posedge clk) disable iff (!rst_n)
    br_spec |=> pend);
  a_r6_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (confirm || redirect) |-> pend);
  a_r6_redirect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !pend);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(confirm && redirect));
  a_r9_link_write: assert property (@(posedge clk) disable iff (!rst_n)
    br_accept && br_link |=> lr == AW'($past(br_pc) + AW'(ILEN)));
  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    br_stall |-> !br_accept && pend);
  a_r12_redirect_drops: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !br_accept);
endmodule

bind branch_resolver branch_resolver_chk #(.AW(AW), .CW(CW), .ILEN(ILEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc),
  .br_use_cr(br_use_cr), .br_use_ctr(br_use_ctr), .br_link(br_link),
  .br_accept(br_accept), .br_stall(br_stall), .br_taken(br_taken),
  .br_spec(br_spec), .pend(pend), .confirm(confirm), .redirect(redirect),
  .lr(lr), .ctr(ctr));

// File: tb/branch_resolver_test.sv
module branch_resolver_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 0, br_use_cr = 0, br_use_ctr = 0, br_ctr_zero = 0;
  logic br_sense = 0, br_hint = 0, br_link = 0;
  logic [31:0] br_pc = '0, br_disp = '0, cr_value = '0, ctr_wdata = '0;
  logic [4:0]  br_cr_idx = '0;
  logic [7:0]  cr_busy = '0;
  logic        fwd_valid = 0, ctr_wr = 0;
  logic [2:0]  fwd_field = '0;
  logic [3:0]  fwd_bits = '0;
  logic br_accept, br_stall, br_taken, br_spec, pend, confirm, redirect;
  logic [31:0] fetch_addr, redirect_addr, lr, ctr;

  always #(PERIOD/2) clk = ~clk;

  branch_resolver uut (.*);

  typedef struct { string req; int sig; logic [31:0] val; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] got(int s);
    case (s)
      0: return {31'd0, br_accept};
      1: return {31'd0, br_taken};
      2: return fetch_addr;
      3: return {31'd0, br_spec};
      4: return {31'd0, confirm};
      5: return {31'd0, redirect};
      6: return redirect_addr;
      7: return lr;
      8: return ctr;
      9: return {31'd0, pend};
      default: return {31'd0, br_stall};
    endcase
  endfunction

  task automatic expect_v(string r, int s, logic [31:0] v);
    exp_t e;
    e.req = r; e.sig = s; e.val = v;
    q.push_back(e);
  endtask

  task automatic next();
    @(negedge clk);
    br_valid = 0; fwd_valid = 0; ctr_wr = 0;
  endtask

  task automatic branch(logic [31:0] pc, logic [31:0] disp, logic ucr, logic uctr,
                        logic cz, logic [4:0] idx, logic sense, logic hint, logic link);
    br_valid = 1; br_pc = pc; br_disp = disp; br_use_cr = ucr; br_use_ctr = uctr;
    br_ctr_zero = cz; br_cr_idx = idx; br_sense = sense; br_hint = hint; br_link = link;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (got(e.sig) !== e.val) begin
          fails++;
          $display("FAIL %s sig%0d actual=%h expected=%h", e.req, e.sig, got(e.sig), e.val);
        end
      end
    end
  end

  initial begin
    #(PERIOD*5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    next();
    expect_v("R1", 9, 0); expect_v("R1", 4, 0); expect_v("R1", 5, 0);
    expect_v("R1", 7, 0); expect_v("R1", 8, 0);
    next(); branch(32'h100, 32'h40, 0, 0, 0, 0, 0, 0, 1);
    expect_v("R2", 0, 1); expect_v("R2", 1, 1); expect_v("R2", 2, 32'h140); expect_v("R2", 3, 0);
    next(); ctr_wr = 1; ctr_wdata = 2;
    expect_v("R9", 7, 32'h104);
    next(); branch(32'h200, 32'hFFFF_FFF0, 0, 1, 0, 0, 0, 0, 0);
    expect_v("R13", 8, 2); expect_v("R3", 1, 1); expect_v("R3", 2, 32'h1F0);
    next(); branch(32'h300, 32'h80, 0, 1, 0, 0, 0, 0, 0);
    expect_v("R3", 8, 1); expect_v("R3", 1, 0); expect_v("R3", 2, 32'h304);
    next(); cr_value = 32'h20; cr_busy = 8'h01; branch(32'h400, 32'h10, 1, 0, 0, 5, 1, 0, 0);
    expect_v("R3", 8, 0); expect_v("R4", 0, 1); expect_v("R4", 1, 1);
    expect_v("R4", 2, 32'h410); expect_v("R4", 3, 0);
    next(); branch(32'h400, 32'h10, 1, 0, 0, 5, 0, 0, 0);
    expect_v("R4", 1, 0); expect_v("R4", 2, 32'h404);
    next(); cr_busy = 8'h02; branch(32'h500, 32'hFFFF_FFE0, 1, 0, 0, 5, 1, 0, 0);
    expect_v("R5", 0, 1); expect_v("R5", 3, 1); expect_v("R5", 1, 1); expect_v("R5", 2, 32'h4E0);
    next();
    expect_v("R5", 9, 1); expect_v("R6", 5, 0); expect_v("R6", 4, 0);
    next(); cr_busy = 8'h00; cr_value = 32'h0; branch(32'h900, 32'h4, 0, 0, 0, 0, 0, 0, 1);
    expect_v("R6", 5, 1); expect_v("R6", 6, 32'h504); expect_v("R6", 4, 0); expect_v("R12", 0, 0);
    next();
    expect_v("R6", 9, 0); expect_v("R12", 7, 32'h104);
    next(); cr_busy = 8'h02; branch(32'h600, 32'h20, 1, 0, 0, 5, 1, 1, 0);
    expect_v("R5", 3, 1); expect_v("R5", 1, 1); expect_v("R5", 2, 32'h620);
    next(); branch(32'h700, 32'h8, 1, 0, 0, 6, 1, 0, 0);
    expect_v("R10", 0, 0); expect_v("R10", 10, 1); expect_v("R8", 4, 0);
    next(); branch(32'h800, 32'h10, 0, 0, 0, 0, 0, 0, 0);
    expect_v("R10", 0, 1); expect_v("R10", 2, 32'h810);
    next(); fwd_valid = 1; fwd_field = 3'd1; fwd_bits = 4'b0010;
    expect_v("R8", 4, 1); expect_v("R8", 5, 0);
    next();
    expect_v("R7", 9, 0);
    next(); branch(32'hA00, 32'h40, 1, 0, 0, 5, 1, 0, 0);
    expect_v("R5", 3, 1); expect_v("R5", 1, 0); expect_v("R5", 2, 32'hA04);
    next(); cr_busy = 8'h00;
    expect_v("R7", 4, 1); expect_v("R7", 5, 0);
    next(); cr_busy = 8'h02; branch(32'hB00, 32'hFFFF_FFF8, 1, 1, 1, 5, 1, 0, 0);
    expect_v("R11", 0, 1); expect_v("R11", 1, 0); expect_v("R11", 3, 0); expect_v("R11", 2, 32'hB04);
    next(); cr_busy = 8'h00;
    expect_v("R11", 9, 0); expect_v("R3", 8, 32'hFFFF_FFFF);
    next();
    next();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule